// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Unit

This block gathers the interrupt causes of a FIFO-capable UART, ranks them and reports the winner as a 4-bit identification code with a pending flag. It holds the sticky causes (line errors, modem changes and the transmit request) in latches. It works out the level-based causes (receive data and character timeout) from the receive FIFO fill level. It clears each cause when the host performs the access that serves it. A character-timeout counter, advanced by a character-time tick, detects a receive FIFO that holds data nobody has collected.

The serial shifters and the FIFOs sit outside this block. Their fill levels, the error and modem-change events and the register access strobes arrive as inputs. The identification code is combinational from the latched state and the current levels. A host read strobe on the identification register samples the code in the same cycle. The FIFO control register shares that address for writes and is decoded by the register front end, so only reads reach this block.

Top module: `uart_irq_ident`

## Requirements
- R1: With no enabled cause active, `irq_id` is 4'b0001 and `irq_pending` is 0. Whenever a cause is reported, `irq_pending` is 1 and `irq_id[0]` is 0. Reset gives 4'b0001.
- R2: Any bit of `lsr_err_evt` (overrun, parity, framing, break) sets a line-status latch, reported as 4'b0110. The latch stays set until a cycle with `rd_lsr` high, and it is clear from the next cycle.
- R3: With `fifo_en` low, a non-zero `rx_level` (buffer full) reports received data, 4'b0100. It disappears once reads bring the level to zero.
- R4: With `fifo_en` high, received data (4'b0100) is reported while `rx_level >= rx_trig`. It disappears when the level falls below the trigger or the FIFO is reset.
- R5: With `fifo_en` high and `rx_level` non-zero, the fourth `char_tick` since the last restart raises character timeout, 4'b1100. In non-FIFO mode, or with an empty FIFO, it never appears.
- R6: A cycle with `rd_rbr`, `rx_push`, `rx_fifo_rst` or `start_bit` high restarts the timeout count. The timeout indication is gone from the next cycle.
- R7: With `fifo_en` high, the transmit request (4'b0010) is latched when `tx_level` changes from above to at-or-below half of TX_DEPTH. This also applies to the first cycle after reset if the level is already there.
- R8: With `fifo_en` low, the transmit request is latched when `thr_empty` rises.
- R9: The transmit request is cleared by `wr_thr`, or by `rd_iir` in a cycle in which 4'b0010 is the reported code. A new transmit event in the same or a later cycle sets it again.
- R10: Any bit of `msr_delta` sets a modem latch, reported as 4'b0000. It is cleared by `rd_msr`.
- R11: The priority order is line status, then received data, then character timeout, then transmit request, then modem status. Data available is shown ahead of timeout when both hold.
- R12: The `ier` bits gate reporting only: bit0 covers received data and timeout, bit1 the transmit request, bit2 line status and bit3 modem status. A masked latch keeps its state and is reported once its bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | FIFO mode select |
| ier | input | 4 | Per-cause report enables |
| lsr_err_evt | input | 4 | Overrun, parity, framing and break event pulses |
| rx_level | input | RX_LW | Receive FIFO fill level |
| rx_trig | input | RX_LW | Receive trigger threshold |
| rx_push | input | 1 | A character entered the receive FIFO |
| rx_fifo_rst | input | 1 | Receive FIFO reset pulse |
| start_bit | input | 1 | Start bit detected on the line |
| char_tick | input | 1 | One character time elapsed |
| tx_level | input | TX_LW | Transmit FIFO fill level |
| thr_empty | input | 1 | Holding register empty (non-FIFO mode) |
| msr_delta | input | 4 | Modem line change flags |
| rd_iir | input | 1 | Identification register read strobe |
| rd_lsr | input | 1 | Line status register read strobe |
| rd_rbr | input | 1 | Receive buffer read strobe |
| wr_thr | input | 1 | Transmit holding register write strobe |
| rd_msr | input | 1 | Modem status register read strobe |
| irq_id | output | 4 | Identification code |
| irq_pending | output | 1 | An enabled cause is reported |

## Verification
The assertions assume that `rx_level` and `tx_level` never exceed their FIFO depths and that `rx_trig` lies between one and RX_DEPTH. They also assume that `start_bit` is not asserted when the timeout limit is zero. The stimulus draws levels and thresholds only inside these ranges and keeps TIMEOUT_CHARS at four. Strobes are single-cycle pulses with no ordering demanded between them, so the random phase also exercises same-cycle set and clear collisions on every latch.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [3:0] {
    ID_NONE    = 4'b0001,
    ID_LINE    = 4'b0110,
    ID_RXDATA  = 4'b0100,
    ID_TIMEOUT = 4'b1100,
    ID_TXREQ   = 4'b0010,
    ID_MODEM   = 4'b0000
  } irq_id_e;

  typedef struct packed {
    logic line;
    logic rxdata;
    logic timeout;
    logic txreq;
    logic modem;
  } irq_src_t;

  // enable bit positions
  localparam int unsigned EN_RX    = 0;
  localparam int unsigned EN_TX    = 1;
  localparam int unsigned EN_LINE  = 2;
  localparam int unsigned EN_MODEM = 3;

  function automatic logic rx_data_due(logic fifo_mode, int unsigned level,
                                       int unsigned trig);
    if (fifo_mode) return (level >= trig);
    return (level != 0);
  endfunction

  function automatic logic tx_room_due(logic fifo_mode, int unsigned level,
                                       int unsigned depth, logic hold_empty);
    if (fifo_mode) return ((level * 2) <= depth);
    return hold_empty;
  endfunction

  function automatic irq_id_e rank(irq_src_t s);
    if (s.line)    return ID_LINE;
    if (s.rxdata)  return ID_RXDATA;
    if (s.timeout) return ID_TIMEOUT;
    if (s.txreq)   return ID_TXREQ;
    if (s.modem)   return ID_MODEM;
    return ID_NONE;
  endfunction

endpackage

// File: rtl/uart_irq_timeout.sv
module uart_irq_timeout #(
  parameter int unsigned RX_LW = 5,
  parameter int unsigned LIMIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic [RX_LW-1:0] rx_level,
  input  logic             char_tick,
  input  logic             rx_push,
  input  logic             rd_rbr,
  input  logic             rx_fifo_rst,
  input  logic             start_bit,
  output logic             tmo_active
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIMIT_V = CW'(LIMIT);

  logic [CW-1:0] cnt_q;
  logic          restart;
  logic          armed;

  assign restart = rx_push | rd_rbr | rx_fifo_rst | start_bit;
  assign armed   = fifo_en && (rx_level != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (restart || !armed)       cnt_q <= '0;
    else if (char_tick && cnt_q != LIMIT_V) cnt_q <= cnt_q + 1'b1;
  end

  assign tmo_active = armed && (cnt_q == LIMIT_V);

  // R5
  tmo_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT_V);

  // R6
  tmo_restart_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tmo_active);

endmodule

// File: rtl/uart_irq_sources.sv
module uart_irq_sources (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] lsr_err_evt,
  input  logic       rd_lsr,
  input  logic [3:0] msr_delta,
  input  logic       rd_msr,
  input  logic       tx_cond,
  input  logic       wr_thr,
  input  logic       iir_tx_ack,
  output logic       line_q,
  output logic       modem_q,
  output logic       txreq_q,
  output logic       tx_evt
);
  logic tx_cond_q;
  logic line_set, modem_set;

  assign line_set  = |lsr_err_evt;
  assign modem_set = |msr_delta;
  assign tx_evt    = tx_cond & ~tx_cond_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q    <= 1'b0;
      modem_q   <= 1'b0;
      txreq_q   <= 1'b0;
      tx_cond_q <= 1'b0;
    end else begin
      tx_cond_q <= tx_cond;
      if (line_set)      line_q <= 1'b1;
      else if (rd_lsr)   line_q <= 1'b0;
      if (modem_set)     modem_q <= 1'b1;
      else if (rd_msr)   modem_q <= 1'b0;
      if (tx_evt)                    txreq_q <= 1'b1;
      else if (wr_thr || iir_tx_ack) txreq_q <= 1'b0;
    end
  end

  // R2
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_q && !rd_lsr) |=> line_q);

  // R9
  tx_ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((iir_tx_ack || wr_thr) && !tx_evt) |=> !txreq_q);

  // R10
  modem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (modem_q && !rd_msr) |=> modem_q);

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int unsigned RX_DEPTH      = 16,
  parameter int unsigned TX_DEPTH      = 16,
  parameter int unsigned TIMEOUT_CHARS = 4,
  localparam int unsigned RX_LW = $clog2(RX_DEPTH + 1),
  localparam int unsigned TX_LW = $clog2(TX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic [3:0]       ier,
  input  logic [3:0]       lsr_err_evt,
  input  logic [RX_LW-1:0] rx_level,
  input  logic [RX_LW-1:0] rx_trig,
  input  logic             rx_push,
  input  logic             rx_fifo_rst,
  input  logic             start_bit,
  input  logic             char_tick,
  input  logic [TX_LW-1:0] tx_level,
  input  logic             thr_empty,
  input  logic [3:0]       msr_delta,
  input  logic             rd_iir,
  input  logic             rd_lsr,
  input  logic             rd_rbr,
  input  logic             wr_thr,
  input  logic             rd_msr,
  output logic [3:0]       irq_id,
  output logic             irq_pending
);
  logic     rx_due, tx_cond, tmo_active;
  logic     line_q, modem_q, txreq_q, tx_evt, iir_tx_ack;
  irq_src_t masked;
  irq_id_e  id_now;

  assign rx_due  = rx_data_due(fifo_en, 32'(rx_level), 32'(rx_trig));
  assign tx_cond = tx_room_due(fifo_en, 32'(tx_level), TX_DEPTH, thr_empty);

  uart_irq_timeout #(.RX_LW(RX_LW), .LIMIT(TIMEOUT_CHARS)) u_tmo (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_level(rx_level),
    .char_tick(char_tick), .rx_push(rx_push), .rd_rbr(rd_rbr),
    .rx_fifo_rst(rx_fifo_rst), .start_bit(start_bit), .tmo_active(tmo_active)
  );

  uart_irq_sources u_src (
    .clk(clk), .rst_n(rst_n), .lsr_err_evt(lsr_err_evt), .rd_lsr(rd_lsr),
    .msr_delta(msr_delta), .rd_msr(rd_msr), .tx_cond(tx_cond),
    .wr_thr(wr_thr), .iir_tx_ack(iir_tx_ack), .line_q(line_q),
    .modem_q(modem_q), .txreq_q(txreq_q), .tx_evt(tx_evt)
  );

  always_comb begin
    masked.line    = line_q     & ier[EN_LINE];
    masked.rxdata  = rx_due     & ier[EN_RX];
    masked.timeout = tmo_active & ier[EN_RX];
    masked.txreq   = txreq_q    & ier[EN_TX];
    masked.modem   = modem_q    & ier[EN_MODEM];
  end

  assign id_now      = rank(masked);
  assign irq_id      = id_now;
  assign irq_pending = (id_now != ID_NONE);
  assign iir_tx_ack  = rd_iir && (id_now == ID_TXREQ);

  // R11
  rx_before_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_due && tmo_active && ier[EN_RX] && !(line_q && ier[EN_LINE]))
      |-> irq_id == 4'b0100);

  // R2
  line_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_q && ier[EN_LINE]) |-> irq_id == 4'b0110);

  // R12
  mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ier == 4'b0000) |-> (irq_id == 4'b0001 && !irq_pending));

endmodule

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;
  localparam int CLK_P = 10;
  localparam int RXD = 16, TXD = 16, LIM = 4;

  logic clk = 0, rst_n = 0;
  logic fifo_en = 1;
  logic [3:0] ier = 4'hF, lsr_err_evt = 0, msr_delta = 0;
  logic [4:0] rx_level = 0, rx_trig = 4, tx_level = 5'd16;
  logic rx_push = 0, rx_fifo_rst = 0, start_bit = 0, char_tick = 0, thr_empty = 0;
  logic rd_iir = 0, rd_lsr = 0, rd_rbr = 0, wr_thr = 0, rd_msr = 0;
  logic [3:0] irq_id;
  logic irq_pending;

  int checks = 0, fails = 0;
  bit done = 0;
  int m_ls = 0, m_ms = 0, m_tx = 0, m_txprev = 0, m_cnt = 0;

  always #(CLK_P/2) clk = ~clk;

  uart_irq_ident #(.RX_DEPTH(RXD), .TX_DEPTH(TXD), .TIMEOUT_CHARS(LIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .ier(ier),
    .lsr_err_evt(lsr_err_evt), .rx_level(rx_level), .rx_trig(rx_trig),
    .rx_push(rx_push), .rx_fifo_rst(rx_fifo_rst), .start_bit(start_bit),
    .char_tick(char_tick), .tx_level(tx_level), .thr_empty(thr_empty),
    .msr_delta(msr_delta), .rd_iir(rd_iir), .rd_lsr(rd_lsr), .rd_rbr(rd_rbr),
    .wr_thr(wr_thr), .rd_msr(rd_msr), .irq_id(irq_id), .irq_pending(irq_pending)
  );

  function automatic logic [3:0] model_code();
    bit rx  = fifo_en ? (int'(rx_level) >= int'(rx_trig)) : (rx_level != 0);
    bit tmo = fifo_en && rx_level != 0 && m_cnt == LIM;
    if (m_ls != 0 && ier[2]) return 4'b0110;
    if (rx && ier[0])        return 4'b0100;
    if (tmo && ier[0])       return 4'b1100;
    if (m_tx != 0 && ier[1]) return 4'b0010;
    if (m_ms != 0 && ier[3]) return 4'b0000;
    return 4'b0001;
  endfunction

  function automatic string tag_of(logic [3:0] c);
    case (c)
      4'b0110: return "R2";
      4'b0100: return fifo_en ? "R4" : "R3";
      4'b1100: return "R5";
      4'b0010: return fifo_en ? "R7" : "R8";
      4'b0000: return "R10";
      default: return "R1";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ls = 0; m_ms = 0; m_tx = 0; m_txprev = 0; m_cnt = 0;
    end else begin
      logic [3:0] shown;
      int cond;
      shown = model_code();
      cond  = fifo_en ? ((int'(tx_level) * 2) <= TXD) : int'(thr_empty);
      if (lsr_err_evt != 0) m_ls = 1; else if (rd_lsr) m_ls = 0;
      if (msr_delta != 0)   m_ms = 1; else if (rd_msr) m_ms = 0;
      if (cond != 0 && m_txprev == 0) m_tx = 1;
      else if (wr_thr || (rd_iir && shown == 4'b0010)) m_tx = 0;
      m_txprev = cond;
      if (rx_push || rd_rbr || rx_fifo_rst || start_bit || !fifo_en || rx_level == 0)
        m_cnt = 0;
      else if (char_tick && m_cnt < LIM) m_cnt++;
    end
  end

  task automatic check(string tag, logic [3:0] got, logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s irq_id got=%b exp=%b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step();
    logic [3:0] e;
    @(negedge clk);
    if (rst_n) begin
      e = model_code();
      check(tag_of(e), irq_id, e);
      checks++;
      if (irq_pending !== (e != 4'b0001)) begin
        fails++;
        $display("FAIL R1 irq_pending got=%b exp=%b", irq_pending, e != 4'b0001);
      end
    end
  endtask

  task automatic clr_strobes();
    lsr_err_evt = 0; msr_delta = 0; rx_push = 0; rx_fifo_rst = 0; start_bit = 0;
    char_tick = 0; rd_iir = 0; rd_lsr = 0; rd_rbr = 0; wr_thr = 0; rd_msr = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin char_tick = 1; step(); char_tick = 0; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", irq_id, 4'b0001);
    checks++; if (irq_pending !== 1'b0) begin fails++; $display("FAIL R1 pending got=%b exp=0", irq_pending); end
    rst_n = 1; step();
    check("R1", irq_id, 4'b0001);

    // R2 line status raise and read clear
    lsr_err_evt = 4'b0010; step(); lsr_err_evt = 0;
    check("R2", irq_id, 4'b0110);
    step(); check("R2", irq_id, 4'b0110);
    rd_lsr = 1; step(); rd_lsr = 0; check("R2", irq_id, 4'b0001);

    // R4 trigger level in FIFO mode
    rx_level = 3; step(); check("R4", irq_id, 4'b0001);
    rx_level = 4; step(); check("R4", irq_id, 4'b0100);
    rx_level = 2; step(); check("R4", irq_id, 4'b0001);

    // R5 timeout after four ticks
    ticks(3); check("R5", irq_id, 4'b0001);
    ticks(1); check("R5", irq_id, 4'b1100);
    // R11 data ahead of timeout
    rx_level = 4; step(); check("R11", irq_id, 4'b0100);
    rx_level = 2; step(); check("R5", irq_id, 4'b1100);
    // R6 clears
    start_bit = 1; step(); start_bit = 0; check("R6", irq_id, 4'b0001);
    ticks(4); check("R5", irq_id, 4'b1100);
    rd_rbr = 1; rx_level = 1; step(); rd_rbr = 0; check("R6", irq_id, 4'b0001);
    ticks(4); check("R5", irq_id, 4'b1100);
    rx_fifo_rst = 1; step(); rx_fifo_rst = 0; rx_level = 0; check("R6", irq_id, 4'b0001);

    // R7 half-empty transmit request and R9 clears
    tx_level = 9; step(); check("R7", irq_id, 4'b0001);
    tx_level = 8; step(); check("R7", irq_id, 4'b0010);
    rd_iir = 1; step(); rd_iir = 0; check("R9", irq_id, 4'b0001);
    tx_level = 12; step(); tx_level = 4; step(); check("R9", irq_id, 4'b0010);
    wr_thr = 1; step(); wr_thr = 0; check("R9", irq_id, 4'b0001);

    // R3 and R8 non-FIFO mode
    fifo_en = 0; tx_level = 16; step();
    rx_level = 1; step(); check("R3", irq_id, 4'b0100);
    ticks(5); check("R5", irq_id, 4'b0100);
    rx_level = 0; step(); check("R3", irq_id, 4'b0001);
    thr_empty = 1; step(); check("R8", irq_id, 4'b0010);
    wr_thr = 1; thr_empty = 0; step(); wr_thr = 0; check("R8", irq_id, 4'b0001);

    // R10 modem and R11 ranking against line status
    msr_delta = 4'b1000; step(); msr_delta = 0; check("R10", irq_id, 4'b0000);
    lsr_err_evt = 4'b0001; step(); lsr_err_evt = 0; check("R11", irq_id, 4'b0110);
    rd_lsr = 1; step(); rd_lsr = 0; check("R11", irq_id, 4'b0000);
    rd_msr = 1; step(); rd_msr = 0; check("R10", irq_id, 4'b0001);

    // R12 masking keeps latched state
    ier = 4'b0000; lsr_err_evt = 4'b0100; step(); lsr_err_evt = 0;
    check("R12", irq_id, 4'b0001);
    ier = 4'b0100; step(); check("R12", irq_id, 4'b0110);
    rd_lsr = 1; step(); rd_lsr = 0; ier = 4'hF; step();

    // randomized phase compared every cycle against the model
    for (int n = 0; n < 3000; n++) begin
      clr_strobes();
      if ($urandom_range(0, 99) == 0) fifo_en = ~fifo_en;
      if ($urandom_range(0, 49) == 0) ier = 4'($urandom);
      if ($urandom_range(0, 19) == 0) lsr_err_evt = 4'($urandom);
      if ($urandom_range(0, 19) == 0) msr_delta = 4'($urandom);
      if ($urandom_range(0, 7) == 0)  rx_level = 5'($urandom_range(0, RXD));
      if ($urandom_range(0, 63) == 0) rx_trig = 5'($urandom_range(1, RXD));
      if ($urandom_range(0, 7) == 0)  tx_level = 5'($urandom_range(0, TXD));
      if ($urandom_range(0, 9) == 0)  thr_empty = ~thr_empty;
      char_tick   = ($urandom_range(0, 2) == 0);
      rx_push     = ($urandom_range(0, 29) == 0);
      rx_fifo_rst = ($urandom_range(0, 79) == 0);
      start_bit   = ($urandom_range(0, 39) == 0);
      rd_iir      = ($urandom_range(0, 5) == 0);
      rd_lsr      = ($urandom_range(0, 9) == 0);
      rd_rbr      = ($urandom_range(0, 19) == 0);
      wr_thr      = ($urandom_range(0, 14) == 0);
      rd_msr      = ($urandom_range(0, 9) == 0);
      step();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule